// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Interrupt Detection

This block is one bank of general-purpose I/O for sixteen pins. Software reaches it through a synchronous register port addressed by word offset. It holds the per-pin direction and output value, and it reports the pin levels after a two-stage synchronizer. It also holds an alternate-function select word and passes it out to an external pad mux.

Each pin can be set to detect either a level or an edge, and its polarity is chosen per pin. Detections set bits in a sticky status register, and software clears those bits by writing. A mask register with a blocking sense gates the status bits into a single interrupt request.

There is no mode that detects both edges. Software gets that behaviour by flipping a pin's edge-polarity bit after each interrupt.

Top module: `gpio_bank`

## Requirements
- R1: While reset (active low) is asserted, all configuration registers and the status register are zero. The outputs `pin_oe`, `pin_out`, `alt_sel` and `irq` are also zero.
- R2: The registers sit at these word offsets (byte offset divided by 4). Mask is at 0, direction at 1, output at 2, trigger kind at 3, edge polarity at 4, level polarity at 5, status at 9, alternate function at 10 and pin level at 12. Each is 16 bits wide and bit n belongs to pin n. A write to a writable register reads back unchanged.
- R3: `pin_oe` follows the direction register (1 = output, 0 = input). `pin_out` follows the output register (0 = drive low). `alt_sel` follows the alternate-function register.
- R4: Offset 12 returns the pin inputs two clock edges after they change. Writes to offset 12 leave every register unchanged.
- R5: A read from any offset not listed in R2 returns zero, and a write to such an offset has no effect.
- R6: When a pin's trigger-kind bit is 1, the pin detects edges. An edge-polarity bit of 1 records rising edges and 0 records falling edges, and the opposite edge records nothing. The status bit is readable three clock edges after the input changes.
- R7: When a pin's trigger-kind bit is 0, the pin detects levels. A level-polarity bit of 1 records a high level and 0 records a low level. The status bit is set again on every cycle the level holds, so a clear cannot remove it while the level persists.
- R8: Status bits are sticky. A write to the status register clears each bit written as 0 and keeps each bit written as 1.
- R9: A detection that happens in the same cycle as a status-clearing write is kept.
- R10: `irq` is high exactly when some status bit is 1 and its mask bit is 0. A masked pin still records its status.
- R11: Software can catch both edges by inverting the edge-polarity bit and clearing status after each detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Word offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output values |
| pin_oe | output | 16 | Output enables |
| alt_sel | output | 16 | Alternate-function select |
| irq | output | 1 | Bank interrupt request |

## Verification
The bench times a rising edge so that its detection lands in the same cycle as a clear write. A design that gave the clear priority would lose that interrupt. It writes a partial mask to the status register, which a design that clears the whole register on any write would fail. It also samples the status one cycle before the expected latency and again at it, which catches a missing or extra synchronizer stage. The wrong-polarity edge case catches an edge detector that ignores the polarity bit. The held-level case catches level detection that is wrongly latched only once. The write to the read-only offset catches a decoder that lets that write land on a configuration register.

// File: rtl/gpio_bank_pkg.sv
// Shared constants for the GPIO bank: data width and register word offsets.
// The offsets are what driver software decodes, so they are fixed values.
package gpio_bank_pkg;
    localparam int PINS  = 16;
    localparam int OFS_W = 4;

    localparam logic [OFS_W-1:0] OFS_MASK = 4'd0;
    localparam logic [OFS_W-1:0] OFS_DIR  = 4'd1;
    localparam logic [OFS_W-1:0] OFS_OUT  = 4'd2;
    localparam logic [OFS_W-1:0] OFS_TRIG = 4'd3;
    localparam logic [OFS_W-1:0] OFS_EPOL = 4'd4;
    localparam logic [OFS_W-1:0] OFS_LPOL = 4'd5;
    localparam logic [OFS_W-1:0] OFS_STAT = 4'd9;
    localparam logic [OFS_W-1:0] OFS_ALT  = 4'd10;
    localparam logic [OFS_W-1:0] OFS_PIN  = 4'd12;
endpackage

// File: rtl/gpio_pin_sync.sv
// Two-flop synchronizer per pin plus one history stage for edge detection.
// Assumes pin inputs are asynchronous. Reset is synchronous and active low.
module gpio_pin_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_async,
    output logic [W-1:0] synced,
    output logic [W-1:0] prev
);
    logic [W-1:0] stage1;

    // Synchronizer chain and previous-cycle copy of the synchronized level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            synced <= '0;
            prev   <= '0;
        end else begin
            stage1 <= pin_async;
            synced <= stage1;
            prev   <= synced;
        end
    end

    // R4
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (prev == $past(synced)));
endmodule

// File: rtl/gpio_detect.sv
// Per-pin detection: level or edge, with per-pin polarity.
// Assumes synced and prev are the current and previous synchronized levels.
module gpio_detect #(
    parameter int W = 16
) (
    input  logic [W-1:0] synced,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] trig_edge,
    input  logic [W-1:0] edge_pol,
    input  logic [W-1:0] level_pol,
    output logic [W-1:0] hit
);
    for (genvar g = 0; g < W; g++) begin : g_pin
        logic lvl_hit;
        logic edg_hit;
        // Level match and polarity-qualified transition for one pin
        always_comb begin
            lvl_hit = (synced[g] == level_pol[g]);
            edg_hit = (synced[g] != prev[g]) && (synced[g] == edge_pol[g]);
            hit[g]  = trig_edge[g] ? edg_hit : lvl_hit;
        end
    end
endmodule

// File: rtl/gpio_regs.sv
// Register file of the bank: configuration registers, sticky status, read mux.
// Assumes a single-cycle write strobe. Reads are combinational on the offset.
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] addr,
    input  logic [W-1:0]     wdata,
    input  logic [W-1:0]     hit,
    input  logic [W-1:0]     synced,
    output logic [W-1:0]     rdata,
    output logic [W-1:0]     mask_q,
    output logic [W-1:0]     dir_q,
    output logic [W-1:0]     out_q,
    output logic [W-1:0]     trig_q,
    output logic [W-1:0]     epol_q,
    output logic [W-1:0]     lpol_q,
    output logic [W-1:0]     alt_q,
    output logic [W-1:0]     stat_q
);
    logic wr_stat;
    assign wr_stat = wr_en && (addr == OFS_STAT);

    // Configuration registers written by offset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            dir_q  <= '0;
            out_q  <= '0;
            trig_q <= '0;
            epol_q <= '0;
            lpol_q <= '0;
            alt_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_MASK: mask_q <= wdata;
                OFS_DIR:  dir_q  <= wdata;
                OFS_OUT:  out_q  <= wdata;
                OFS_TRIG: trig_q <= wdata;
                OFS_EPOL: epol_q <= wdata;
                OFS_LPOL: lpol_q <= wdata;
                OFS_ALT:  alt_q  <= wdata;
                default:  ;
            endcase
        end
    end

    // Sticky status: the write clears bits written as 0, new detections always set
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (wr_stat ? (stat_q & wdata) : stat_q) | hit;
    end

    // Read mux, zero on unused offsets
    always_comb begin
        case (addr)
            OFS_MASK: rdata = mask_q;
            OFS_DIR:  rdata = dir_q;
            OFS_OUT:  rdata = out_q;
            OFS_TRIG: rdata = trig_q;
            OFS_EPOL: rdata = epol_q;
            OFS_LPOL: rdata = lpol_q;
            OFS_STAT: rdata = stat_q;
            OFS_ALT:  rdata = alt_q;
            OFS_PIN:  rdata = synced;
            default:  rdata = '0;
        endcase
    end

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
    // R8
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wdata == '0 && hit == '0) |=> (stat_q == '0));
    // R9
    hit_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((stat_q & $past(hit)) == $past(hit)));
    // R4
    ro_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_PIN) |=> ($stable(mask_q) && $stable(dir_q) &&
        $stable(out_q) && $stable(trig_q) && $stable(epol_q) &&
        $stable(lpol_q) && $stable(alt_q)));
endmodule

// File: rtl/gpio_bank.sv
// Top of one 16-pin GPIO bank: synchronizer, detectors, registers and the
// masked interrupt request. Assumes one clock domain for the register port.
module gpio_bank
    import gpio_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] addr,
    input  logic [PINS-1:0]  wdata,
    output logic [PINS-1:0]  rdata,
    input  logic [PINS-1:0]  pin_in,
    output logic [PINS-1:0]  pin_out,
    output logic [PINS-1:0]  pin_oe,
    output logic [PINS-1:0]  alt_sel,
    output logic             irq
);
    logic [PINS-1:0] synced, prev, hit;
    logic [PINS-1:0] mask_q, dir_q, out_q, trig_q, epol_q, lpol_q, alt_q, stat_q;

    gpio_pin_sync #(.W(PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_in),
        .synced(synced), .prev(prev)
    );

    gpio_detect #(.W(PINS)) u_detect (
        .synced(synced), .prev(prev), .trig_edge(trig_q),
        .edge_pol(epol_q), .level_pol(lpol_q), .hit(hit)
    );

    gpio_regs #(.W(PINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .hit(hit), .synced(synced), .rdata(rdata),
        .mask_q(mask_q), .dir_q(dir_q), .out_q(out_q), .trig_q(trig_q),
        .epol_q(epol_q), .lpol_q(lpol_q), .alt_q(alt_q), .stat_q(stat_q)
    );

    // Pad-side outputs and the bank interrupt
    always_comb begin
        pin_out = out_q;
        pin_oe  = dir_q;
        alt_sel = alt_q;
        irq     = |(stat_q & ~mask_q);
    end

    // R10
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(hit) != '0 || $past(wr_en && addr == OFS_MASK)));
endmodule

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
    import gpio_bank_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [OFS_W-1:0] addr = '0;
    logic [15:0]      wdata = '0;
    logic [15:0]      rdata, pin_out, pin_oe, alt_sel;
    logic [15:0]      pin_in = '0;
    logic             irq;
    int               total = 0;
    int               bad = 0;

    always #2 clk = ~clk;

    gpio_bank u_gpio_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .alt_sel(alt_sel), .irq(irq)
    );

    // {offset, write value, expected readback}
    localparam logic [35:0] VEC [10] = '{
        {4'd0,  16'hA5A5, 16'hA5A5},
        {4'd1,  16'h00FF, 16'h00FF},
        {4'd2,  16'h1234, 16'h1234},
        {4'd3,  16'h5A5A, 16'h5A5A},
        {4'd4,  16'h0F0F, 16'h0F0F},
        {4'd5,  16'hFFFF, 16'hFFFF},
        {4'd10, 16'h8001, 16'h8001},
        {4'd6,  16'hBEEF, 16'h0000},
        {4'd15, 16'hFFFF, 16'h0000},
        {4'd12, 16'hFFFF, 16'h0000}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [15:0] v;
        // R1 reset state
        idle(3);
        chk("R1 pin_oe", pin_oe, 16'h0);
        chk("R1 pin_out", pin_out, 16'h0);
        chk("R1 alt_sel", alt_sel, 16'h0);
        chk("R1 irq", {15'h0, irq}, 16'h0);
        rd(OFS_MASK, v); chk("R1 mask", v, 16'h0);
        rd(OFS_STAT, v); chk("R1 status", v, 16'h0);
        rst_n = 1'b1;

        // R2 R5 register table
        for (int i = 0; i < 10; i++) begin
            wr(VEC[i][35:32], VEC[i][31:16]);
            rd(VEC[i][35:32], v);
            chk("R2/R5 readback", v, VEC[i][15:0]);
        end
        // R3 pad outputs
        chk("R3 pin_oe", pin_oe, 16'h00FF);
        chk("R3 pin_out", pin_out, 16'h1234);
        chk("R3 alt_sel", alt_sel, 16'h8001);

        // setup: pins 0..3 edge (0,2 rising; 1,3 falling), others high level
        wr(OFS_TRIG, 16'h000F);
        wr(OFS_EPOL, 16'h0005);
        wr(OFS_LPOL, 16'hFFFF);
        wr(OFS_MASK, 16'hFFFF);
        idle(3);
        wr(OFS_STAT, 16'h0000);
        rd(OFS_STAT, v); chk("R8 cleared", v, 16'h0);

        // R6 rising edge and its latency
        pin_in[0] = 1'b1;
        idle(2);
        rd(OFS_STAT, v); chk("R6 before latency", v, 16'h0000);
        idle(1);
        rd(OFS_STAT, v); chk("R6 rising recorded", v, 16'h0001);
        // R6 falling-polarity pin ignores its rising edge
        pin_in[1] = 1'b1;
        idle(4);
        rd(OFS_STAT, v); chk("R6 wrong edge ignored", v, 16'h0001);
        pin_in[1] = 1'b0;
        idle(4);
        rd(OFS_STAT, v); chk("R6 falling recorded", v, 16'h0003);
        // R8 partial clear
        wr(OFS_STAT, 16'h0001);
        rd(OFS_STAT, v); chk("R8 partial clear", v, 16'h0001);
        wr(OFS_STAT, 16'h0000);
        pin_in[0] = 1'b0;
        idle(4);
        rd(OFS_STAT, v); chk("R8 stays clear", v, 16'h0000);

        // R10 masked pin records, irq gated by mask
        pin_in[2] = 1'b1;
        idle(4);
        rd(OFS_STAT, v); chk("R10 masked still records", v, 16'h0004);
        chk("R10 irq masked", {15'h0, irq}, 16'h0);
        wr(OFS_MASK, 16'hFFFB);
        chk("R10 irq unmasked", {15'h0, irq}, 16'h1);
        wr(OFS_STAT, 16'h0000);
        chk("R10 irq after clear", {15'h0, irq}, 16'h0);

        // R11 both edges by flipping polarity
        wr(OFS_EPOL, 16'h000D);
        pin_in[3] = 1'b1;
        idle(4);
        rd(OFS_STAT, v); chk("R11 first edge", v, 16'h0008);
        wr(OFS_EPOL, 16'h0005);
        wr(OFS_STAT, 16'h0000);
        pin_in[3] = 1'b0;
        idle(4);
        rd(OFS_STAT, v); chk("R11 second edge", v, 16'h0008);

        // R9 detection coincides with clearing write
        pin_in[2] = 1'b0;
        idle(4);
        wr(OFS_STAT, 16'h0000);
        pin_in[2] = 1'b1;
        @(negedge clk);
        wr(OFS_STAT, 16'h0000);
        rd(OFS_STAT, v); chk("R9 detection kept", v, 16'h0004);
        chk("R9 irq", {15'h0, irq}, 16'h1);

        // R4 pin level read latency and read-only offset
        pin_in[9] = 1'b1;
        idle(1);
        rd(OFS_PIN, v); chk("R4 old level", v, 16'h0004);
        idle(1);
        rd(OFS_PIN, v); chk("R4 new level", v, 16'h0204);
        wr(OFS_PIN, 16'h0000);
        rd(OFS_PIN, v); chk("R4 write ignored", v, 16'h0204);
        rd(OFS_DIR, v); chk("R4 dir untouched", v, 16'h00FF);

        // R7 held level survives clear, then clears once released
        idle(2);
        wr(OFS_STAT, 16'h0000);
        rd(OFS_STAT, v); chk("R7 held level", v, 16'h0200);
        pin_in[9] = 1'b0;
        idle(4);
        wr(OFS_STAT, 16'h0000);
        rd(OFS_STAT, v); chk("R7 released", v, 16'h0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule